// File: doc/BRIEF.md
# Bayer White Balance Zone Statistics

This block watches a raw Bayer pixel stream, one pixel per clock, marked with a start-of-frame flag on the first pixel and an end-of-line flag on the last pixel of every line. It pairs even and odd lines into 2x2 colour filter quads. For each of the two filter columns of a quad, it forms a fixed-point ratio of one pixel over the other. A quad counts only when both column ratios lie inside programmable bounds. Each accepted quad adds its two ratios to the running sums of the zone it falls in, and adds one to that zone's quad count.

Zones tile a programmable region of interest in a grid of 7 columns by 7 rows. Their width and height are programmable pixel counts. Quads beyond the seventh zone column or row are not counted. Software, or a downstream controller, selects a zone on a read port and gets back that zone's two ratio sums and its count. An 8-bit running checksum of the frame's pixels is also visible. Every accumulator restarts at each start of frame, so the results describe the most recent frame.

Top module: `wbz_zone_stats`

## Requirements
- R1: After synchronous reset, every zone reads zero on all three read outputs, and `frame_sum` is zero.
- R2: `frame_sum` is the 8-bit modulo sum of the pixels accepted since the start-of-frame pixel, that pixel included. It changes on the edge that accepts a pixel and holds while `in_valid` is low.
- R3: A quad is pixels (x,y), (x+1,y), (x,y+1) and (x+1,y+1) with x and y even. Column X0 is the physical left column when `cfg_phase[0]`=0 and the right column when it is 1; X1 is the other column. In column X0 the numerator is the bottom pixel when `cfg_phase[1]` XOR `cfg_inv[1]` is 1, and the top pixel otherwise. Column X1 uses `cfg_phase[1]` XOR `cfg_inv[0]` the same way. The other pixel of each column is its denominator.
- R4: A column ratio is floor(num * 2^FRAC_W / den), held in PIX_W+FRAC_W bits. A zero denominator gives all ones.
- R5: A 32-bit bound in unsigned 16.16 is converted to a comparison value as {bits[16 +: PIX_W], bits[15 -: FRAC_W]}. A quad is accepted only if lo0 <= ratio0 <= hi0 and lo1 <= ratio1 <= hi1. A rejected quad changes no zone.
- R6: A quad is counted only when all four of its pixels lie inside the region x in [`roi_x0`, `roi_x1`) and y in [`roi_y0`, `roi_y1`). Start values and sizes are even.
- R7: A quad with top-left pixel (x,y) belongs to zone column (x-`roi_x0`)/`zone_w` and zone row (y-`roi_y0`)/`zone_h`. If either is 7 or more, the quad is dropped. Zone column c, row r is read at `rd_zone` = 7*r + c.
- R8: For an accepted quad, its zone's `rd_sum0` grows by ratio0, `rd_sum1` by ratio1 and `rd_count` by 1. The new values are visible after the second rising edge, counting the edge that accepts the quad's bottom-right pixel.
- R9: The edge after the one that accepts a start-of-frame pixel clears all zones to zero.
- R10: For `rd_zone` values 49 to 63, all three read outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel present this cycle |
| in_data | input | PIX_W | Pixel value |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| cfg_phase | input | 2 | Colour order of the top-left quad |
| cfg_inv | input | 2 | Per-column numerator/denominator swap |
| roi_x0 | input | COORD_W | Region first column |
| roi_y0 | input | COORD_W | Region first line |
| roi_x1 | input | COORD_W | Region last column plus one |
| roi_y1 | input | COORD_W | Region last line plus one |
| zone_w | input | COORD_W | Zone width in pixels, even |
| zone_h | input | COORD_W | Zone height in pixels, even |
| lim_lo0 | input | 32 | Column X0 lower bound, 16.16 |
| lim_hi0 | input | 32 | Column X0 upper bound, 16.16 |
| lim_lo1 | input | 32 | Column X1 lower bound, 16.16 |
| lim_hi1 | input | 32 | Column X1 upper bound, 16.16 |
| rd_zone | input | 6 | Zone selected for readout |
| rd_sum0 | output | SUM_W | Sum of X0 ratios for the selected zone |
| rd_sum1 | output | SUM_W | Sum of X1 ratios for the selected zone |
| rd_count | output | CNT_W | Accepted quads in the selected zone |
| frame_sum | output | 8 | Running pixel checksum of the frame |

## Verification
A wrong line buffer entry or wrong position counter puts ratios into the wrong zone, or uses the wrong pixels. This shows up as mismatched sums on a full readout taken a few cycles after each frame ends. A checksum fault shows on `frame_sum` at the very next clock, because that output is compared every cycle. A missed clear leaves the previous frame's counts in place. This is caught by a read of zone 0 after the first line of the next frame, before any quad of that frame can have arrived.

// File: rtl/wbz_pkg.sv
package wbz_pkg;

    localparam int GRID_N = 7;
    localparam int ZONE_N = GRID_N * GRID_N;
    localparam int ZIDX_W = $clog2(ZONE_N);
    localparam int GPOS_W = $clog2(GRID_N + 1);

    typedef logic [ZIDX_W-1:0] zone_idx_t;
    typedef logic [GPOS_W-1:0] gpos_t;

    // grid position GRID_N marks "beyond the grid"
    localparam gpos_t GPOS_OUT = gpos_t'(GRID_N);

    typedef enum logic [1:0] {
        PH_NORMAL = 2'b00,
        PH_HFLIP  = 2'b01,
        PH_VFLIP  = 2'b10,
        PH_BOTH   = 2'b11
    } phase_e;

    typedef struct packed {
        gpos_t col;
        gpos_t row;
    } zone_xy_t;

    function automatic gpos_t grid_step(gpos_t g);
        return (g == GPOS_OUT) ? g : g + gpos_t'(1);
    endfunction

    function automatic logic zone_inside(zone_xy_t p);
        return (p.col < GPOS_OUT) && (p.row < GPOS_OUT);
    endfunction

    function automatic zone_idx_t zone_linear(zone_xy_t p);
        return zone_idx_t'(p.row) * zone_idx_t'(GRID_N) + zone_idx_t'(p.col);
    endfunction

endpackage

// File: rtl/wbz_geom.sv
module wbz_geom
    import wbz_pkg::*;
#(
    parameter int PIX_W    = 8,
    parameter int COORD_W  = 16,
    parameter int LINE_MAX = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [PIX_W-1:0]   in_data,
    input  logic               in_sof,
    input  logic               in_eol,
    input  logic [COORD_W-1:0] roi_x0,
    input  logic [COORD_W-1:0] roi_y0,
    input  logic [COORD_W-1:0] roi_x1,
    input  logic [COORD_W-1:0] roi_y1,
    input  logic [COORD_W-1:0] zone_w,
    input  logic [COORD_W-1:0] zone_h,
    output logic               q_vld,
    output logic [PIX_W-1:0]   q_tl,
    output logic [PIX_W-1:0]   q_tr,
    output logic [PIX_W-1:0]   q_bl,
    output logic [PIX_W-1:0]   q_br,
    output zone_idx_t          q_zone,
    output logic               q_clr
);

    localparam int PAIR_N  = LINE_MAX / 2;
    localparam int PAIR_AW = $clog2(PAIR_N);
    localparam logic [COORD_W-1:0] ONE = COORD_W'(1);

    logic [COORD_W-1:0] x_q, y_q, cx, cy;
    logic [COORD_W-1:0] hoff_q, voff_q, ch_off, cv_off;
    gpos_t              hcol_q, vrow_q, ch_col, cv_row;
    logic               h_in, v_in, in_line, fire;
    logic [PAIR_AW-1:0] pidx;
    logic [PIX_W-1:0]   prev_q;
    logic [2*PIX_W-1:0] pair_mem [PAIR_N];
    logic [2*PIX_W-1:0] pair_rd;
    zone_xy_t           cur_zone;

    // a start-of-frame pixel restarts every position counter
    assign cx     = in_sof ? '0 : x_q;
    assign cy     = in_sof ? '0 : y_q;
    assign ch_off = in_sof ? '0 : hoff_q;
    assign ch_col = in_sof ? '0 : hcol_q;
    assign cv_off = in_sof ? '0 : voff_q;
    assign cv_row = in_sof ? '0 : vrow_q;

    assign h_in    = (cx >= roi_x0) && (cx < roi_x1);
    assign v_in    = (cy >= roi_y0) && (cy < roi_y1);
    assign in_line = cx < COORD_W'(LINE_MAX);
    assign pidx    = PAIR_AW'(cx >> 1);
    assign pair_rd = pair_mem[pidx];

    assign cur_zone.col = ch_col;
    assign cur_zone.row = cv_row;

    assign fire = in_valid && cx[0] && cy[0] && in_line && h_in && v_in
                  && zone_inside(cur_zone);

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q    <= '0;
            y_q    <= '0;
            hoff_q <= '0;
            hcol_q <= '0;
            voff_q <= '0;
            vrow_q <= '0;
            prev_q <= '0;
        end else if (in_valid) begin
            prev_q <= in_data;
            if (in_eol) begin
                x_q    <= '0;
                y_q    <= cy + ONE;
                hoff_q <= '0;
                hcol_q <= '0;
                if (v_in && (cv_off == zone_h - ONE)) begin
                    voff_q <= '0;
                    vrow_q <= grid_step(cv_row);
                end else if (v_in) begin
                    voff_q <= cv_off + ONE;
                    vrow_q <= cv_row;
                end else begin
                    voff_q <= cv_off;
                    vrow_q <= cv_row;
                end
            end else begin
                x_q    <= cx + ONE;
                y_q    <= cy;
                voff_q <= cv_off;
                vrow_q <= cv_row;
                if (h_in && (ch_off == zone_w - ONE)) begin
                    hoff_q <= '0;
                    hcol_q <= grid_step(ch_col);
                end else if (h_in) begin
                    hoff_q <= ch_off + ONE;
                    hcol_q <= ch_col;
                end else begin
                    hoff_q <= ch_off;
                    hcol_q <= ch_col;
                end
            end
        end
    end

    // top-row pairs of even lines, read back on the following odd line
    always_ff @(posedge clk) begin
        if (in_valid && !cy[0] && cx[0] && in_line)
            pair_mem[pidx] <= {prev_q, in_data};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_vld <= 1'b0;
            q_clr <= 1'b0;
        end else begin
            q_vld <= fire;
            q_clr <= in_valid && in_sof;
        end
    end

    always_ff @(posedge clk) begin
        q_tl   <= pair_rd[2*PIX_W-1 -: PIX_W];
        q_tr   <= pair_rd[PIX_W-1:0];
        q_bl   <= prev_q;
        q_br   <= in_data;
        q_zone <= zone_linear(cur_zone);
    end

    // quads complete only on an odd pixel of an odd line
    assert_fire_odd_R6: assert property (@(posedge clk) disable iff (rst)
        q_vld |-> $past(in_valid && cx[0] && cy[0]));

    assert_zone_range_R7: assert property (@(posedge clk) disable iff (rst)
        q_vld |-> (q_zone < zone_idx_t'(ZONE_N)));

endmodule

// File: rtl/wbz_ratio.sv
module wbz_ratio #(
    parameter int PIX_W  = 8,
    parameter int FRAC_W = 8,
    localparam int RAT_W = PIX_W + FRAC_W
) (
    input  logic [PIX_W-1:0]            tl,
    input  logic [PIX_W-1:0]            tr,
    input  logic [PIX_W-1:0]            bl,
    input  logic [PIX_W-1:0]            br,
    input  logic [1:0]                  phase,
    input  logic [1:0]                  inv,
    input  logic [1:0][31:0]            lim_lo,
    input  logic [1:0][31:0]            lim_hi,
    output logic [1:0][RAT_W-1:0]       rat,
    output logic                        pass
);

    localparam int XW = RAT_W + PIX_W + 1;

    logic [1:0] ok;

    for (genvar g = 0; g < 2; g++) begin : g_col
        localparam logic IS_X1  = (g == 1);
        localparam int   INV_B  = 1 - g;

        logic             sel_r, swap;
        logic [PIX_W-1:0] t, b, n, d;
        logic [RAT_W-1:0] dvd, q, lo_c, hi_c;
        logic [XW-1:0]    prod;

        assign sel_r = phase[0] ^ IS_X1;
        assign t     = sel_r ? tr : tl;
        assign b     = sel_r ? br : bl;
        assign swap  = phase[1] ^ inv[INV_B];
        assign n     = swap ? b : t;
        assign d     = swap ? t : b;

        assign dvd  = {n, {FRAC_W{1'b0}}};
        assign q    = (d == '0) ? '1 : dvd / RAT_W'(d);
        assign lo_c = {lim_lo[g][16 +: PIX_W], lim_lo[g][15 -: FRAC_W]};
        assign hi_c = {lim_hi[g][16 +: PIX_W], lim_hi[g][15 -: FRAC_W]};

        assign ok[g]  = (q >= lo_c) && (q <= hi_c);
        assign rat[g] = q;

        assign prod = XW'(q) * XW'(d);

        // quotient is the floor of the division when the divisor is non-zero
        always_comb begin
            if (d != '0) begin
                assert_ratio_floor_R4: assert ((prod <= XW'(dvd)) && (XW'(dvd) < prod + XW'(d)));
            end
        end
    end

    assign pass = &ok;

endmodule

// File: rtl/wbz_zone_bank.sv
module wbz_zone_bank
    import wbz_pkg::*;
#(
    parameter int RAT_W = 16,
    parameter int SUM_W = 28,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             upd,
    input  logic             pass,
    input  zone_idx_t        zone,
    input  logic [RAT_W-1:0] r0,
    input  logic [RAT_W-1:0] r1,
    input  zone_idx_t        rd_zone,
    output logic [SUM_W-1:0] rd_sum0,
    output logic [SUM_W-1:0] rd_sum1,
    output logic [CNT_W-1:0] rd_count
);

    localparam zone_idx_t ZLIM = zone_idx_t'(ZONE_N);

    logic [SUM_W-1:0] s0_q [ZONE_N];
    logic [SUM_W-1:0] s1_q [ZONE_N];
    logic [CNT_W-1:0] c_q  [ZONE_N];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int z = 0; z < ZONE_N; z++) begin
                s0_q[z] <= '0;
                s1_q[z] <= '0;
                c_q[z]  <= '0;
            end
        end else if (upd && pass && (zone < ZLIM)) begin
            s0_q[zone] <= s0_q[zone] + SUM_W'(r0);
            s1_q[zone] <= s1_q[zone] + SUM_W'(r1);
            c_q[zone]  <= c_q[zone] + CNT_W'(1);
        end
    end

    always_comb begin
        if (rd_zone < ZLIM) begin
            rd_sum0  = s0_q[rd_zone];
            rd_sum1  = s1_q[rd_zone];
            rd_count = c_q[rd_zone];
        end else begin
            rd_sum0  = '0;
            rd_sum1  = '0;
            rd_count = '0;
        end
    end

    // observation registers for the step check below
    zone_idx_t        chk_zone_q;
    logic [CNT_W-1:0] chk_cnt_q;
    logic             chk_arm_q, chk_pass_q;

    always_ff @(posedge clk) begin
        if (rst) chk_arm_q <= 1'b0;
        else     chk_arm_q <= upd && !clr && (zone < ZLIM);
        chk_zone_q <= zone;
        chk_cnt_q  <= c_q[zone];
        chk_pass_q <= pass;
    end

    // a quad moves its zone count by one when accepted, by none when rejected (R5)
    assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
        chk_arm_q |-> (c_q[chk_zone_q] == chk_cnt_q + (chk_pass_q ? CNT_W'(1) : CNT_W'(0))));

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> ((c_q[0] == '0) && (s0_q[ZONE_N-1] == '0) && (s1_q[ZONE_N-1] == '0)));

endmodule

// File: rtl/wbz_zone_stats.sv
module wbz_zone_stats
    import wbz_pkg::*;
#(
    parameter int PIX_W    = 8,
    parameter int FRAC_W   = 8,
    parameter int COORD_W  = 16,
    parameter int LINE_MAX = 64,
    parameter int CNT_W    = 12,
    parameter int SUM_W    = 28
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [PIX_W-1:0]   in_data,
    input  logic               in_sof,
    input  logic               in_eol,
    input  logic [1:0]         cfg_phase,
    input  logic [1:0]         cfg_inv,
    input  logic [COORD_W-1:0] roi_x0,
    input  logic [COORD_W-1:0] roi_y0,
    input  logic [COORD_W-1:0] roi_x1,
    input  logic [COORD_W-1:0] roi_y1,
    input  logic [COORD_W-1:0] zone_w,
    input  logic [COORD_W-1:0] zone_h,
    input  logic [31:0]        lim_lo0,
    input  logic [31:0]        lim_hi0,
    input  logic [31:0]        lim_lo1,
    input  logic [31:0]        lim_hi1,
    input  logic [5:0]         rd_zone,
    output logic [SUM_W-1:0]   rd_sum0,
    output logic [SUM_W-1:0]   rd_sum1,
    output logic [CNT_W-1:0]   rd_count,
    output logic [7:0]         frame_sum
);

    localparam int RAT_W = PIX_W + FRAC_W;

    logic                  q_vld, q_clr, q_pass;
    logic [PIX_W-1:0]      q_tl, q_tr, q_bl, q_br;
    zone_idx_t             q_zone;
    logic [1:0][RAT_W-1:0] q_rat;

    wbz_geom #(
        .PIX_W(PIX_W), .COORD_W(COORD_W), .LINE_MAX(LINE_MAX)
    ) u_geom (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eol(in_eol),
        .roi_x0(roi_x0), .roi_y0(roi_y0), .roi_x1(roi_x1), .roi_y1(roi_y1),
        .zone_w(zone_w), .zone_h(zone_h),
        .q_vld(q_vld), .q_tl(q_tl), .q_tr(q_tr), .q_bl(q_bl), .q_br(q_br),
        .q_zone(q_zone), .q_clr(q_clr)
    );

    wbz_ratio #(
        .PIX_W(PIX_W), .FRAC_W(FRAC_W)
    ) u_ratio (
        .tl(q_tl), .tr(q_tr), .bl(q_bl), .br(q_br),
        .phase(cfg_phase), .inv(cfg_inv),
        .lim_lo({lim_lo1, lim_lo0}), .lim_hi({lim_hi1, lim_hi0}),
        .rat(q_rat), .pass(q_pass)
    );

    wbz_zone_bank #(
        .RAT_W(RAT_W), .SUM_W(SUM_W), .CNT_W(CNT_W)
    ) u_bank (
        .clk(clk), .rst(rst), .clr(q_clr), .upd(q_vld), .pass(q_pass),
        .zone(q_zone), .r0(q_rat[0]), .r1(q_rat[1]),
        .rd_zone(rd_zone),
        .rd_sum0(rd_sum0), .rd_sum1(rd_sum1), .rd_count(rd_count)
    );

    always_ff @(posedge clk) begin
        if (rst)
            frame_sum <= '0;
        else if (in_valid)
            frame_sum <= in_sof ? 8'(in_data) : frame_sum + 8'(in_data);
    end

    assert_sum_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(frame_sum));

endmodule

// File: tb/sim_wbz_zone_stats.sv
module sim_wbz_zone_stats;

    localparam int PIX_W = 8, FRAC_W = 8, COORD_W = 16, LINE_MAX = 64;
    localparam int CNT_W = 12, SUM_W = 28;
    localparam int RMAX = (1 << (PIX_W + FRAC_W)) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
    logic [PIX_W-1:0] in_data = '0;
    logic [1:0] cfg_phase = '0, cfg_inv = '0;
    logic [COORD_W-1:0] roi_x0 = '0, roi_y0 = '0, roi_x1 = '0, roi_y1 = '0;
    logic [COORD_W-1:0] zone_w = 16'd2, zone_h = 16'd2;
    logic [31:0] lim_lo0 = '0, lim_hi0 = '0, lim_lo1 = '0, lim_hi1 = '0;
    logic [5:0] rd_zone = '0;
    logic [SUM_W-1:0] rd_sum0, rd_sum1;
    logic [CNT_W-1:0] rd_count;
    logic [7:0] frame_sum;

    always #4 clk = ~clk;

    wbz_zone_stats #(
        .PIX_W(PIX_W), .FRAC_W(FRAC_W), .COORD_W(COORD_W),
        .LINE_MAX(LINE_MAX), .CNT_W(CNT_W), .SUM_W(SUM_W)
    ) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eol(in_eol), .cfg_phase(cfg_phase), .cfg_inv(cfg_inv),
        .roi_x0(roi_x0), .roi_y0(roi_y0), .roi_x1(roi_x1), .roi_y1(roi_y1),
        .zone_w(zone_w), .zone_h(zone_h),
        .lim_lo0(lim_lo0), .lim_hi0(lim_hi0), .lim_lo1(lim_lo1), .lim_hi1(lim_hi1),
        .rd_zone(rd_zone), .rd_sum0(rd_sum0), .rd_sum1(rd_sum1),
        .rd_count(rd_count), .frame_sum(frame_sum)
    );

    int vecs = 0;
    int bad = 0;
    int img [64][64];
    longint es0 [49];
    longint es1 [49];
    longint ec  [49];
    int exp_cs = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        vecs++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // behavioural checksum model, compared every clock
    always @(posedge clk) begin
        if (rst) exp_cs <= 0;
        else if (in_valid) exp_cs <= in_sof ? int'(in_data) : ((exp_cs + int'(in_data)) & 255);
    end

    always @(negedge clk) begin
        if (cmp_on && !rst)
            check(int'(frame_sum) == exp_cs, "R2", "frame_sum", frame_sum, exp_cs);
    end

    function automatic int conv(input logic [31:0] b);
        return (((b >> 16) & 32'hFF) << FRAC_W) | ((b & 32'hFFFF) >> (16 - FRAC_W));
    endfunction

    function automatic int ratio(input int n, input int d);
        if (d == 0) return RMAX;
        return (n << FRAC_W) / d;
    endfunction

    task automatic fill(input int mode, input int w, input int h);
        for (int y = 0; y < h; y++)
            for (int x = 0; x < w; x++)
                case (mode)
                    0: img[y][x] = (x * 7 + y * 13 + 3) % 256;
                    1: img[y][x] = ((x * 31 + y * 17) ^ (x * y)) % 256;
                    2: img[y][x] = ((y % 2 == 1) && (x % 3 == 0)) ? 0 : (x * 5 + y * 11 + 40) % 256;
                    default: img[y][x] = (x * x + 3 * y + 1) % 256;
                endcase
    endtask

    task automatic model();
        int hs, he, vs, ve, zx, zy, z, t0, b0, t1, b1, n0, d0, n1, d1, r0, r1;
        hs = int'(roi_x0); he = int'(roi_x1); vs = int'(roi_y0); ve = int'(roi_y1);
        for (int i = 0; i < 49; i++) begin es0[i] = 0; es1[i] = 0; ec[i] = 0; end
        for (int y = vs; y + 1 < ve; y += 2)
            for (int x = hs; x + 1 < he; x += 2) begin
                zx = (x - hs) / int'(zone_w);
                zy = (y - vs) / int'(zone_h);
                if (zx < 7 && zy < 7) begin
                    z = zy * 7 + zx;
                    if (cfg_phase[0]) begin
                        t0 = img[y][x+1]; b0 = img[y+1][x+1]; t1 = img[y][x]; b1 = img[y+1][x];
                    end else begin
                        t0 = img[y][x]; b0 = img[y+1][x]; t1 = img[y][x+1]; b1 = img[y+1][x+1];
                    end
                    if (cfg_phase[1] ^ cfg_inv[1]) begin n0 = b0; d0 = t0; end
                    else begin n0 = t0; d0 = b0; end
                    if (cfg_phase[1] ^ cfg_inv[0]) begin n1 = b1; d1 = t1; end
                    else begin n1 = t1; d1 = b1; end
                    r0 = ratio(n0, d0);
                    r1 = ratio(n1, d1);
                    if (r0 >= conv(lim_lo0) && r0 <= conv(lim_hi0) &&
                        r1 >= conv(lim_lo1) && r1 <= conv(lim_hi1)) begin
                        es0[z] += r0; es1[z] += r1; ec[z] += 1;
                    end
                end
            end
    endtask

    task automatic send_frame(input int w, input int h, input bit gaps, input bit mid_chk);
        for (int y = 0; y < h; y++) begin
            for (int x = 0; x < w; x++) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_data  = PIX_W'(img[y][x]);
                in_sof   = (x == 0) && (y == 0);
                in_eol   = (x == w - 1);
                if (gaps && (x % 5 == 4)) begin
                    @(negedge clk);
                    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
                end
            end
            if (mid_chk && y == 0) begin
                @(negedge clk);
                in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
                rd_zone = 6'd0;
                #1;
                check(rd_count == '0 && rd_sum0 == '0, "R9", "zone0 count after new frame start",
                      longint'(rd_count), 0);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_zones(input string req);
        for (int z = 0; z < 49; z++) begin
            @(negedge clk);
            rd_zone = 6'(z);
            #1;
            check(longint'(rd_sum0) == es0[z] && longint'(rd_sum1) == es1[z] &&
                  longint'(rd_count) == ec[z], req, $sformatf("zone %0d count/sum0", z),
                  longint'(rd_count) * 1000000 + longint'(rd_sum0), ec[z] * 1000000 + es0[z]);
        end
    endtask

    task automatic setup(input int ph, input int iv, input int x0, input int y0,
                         input int x1, input int y1, input int zw, input int zh,
                         input logic [31:0] l0, input logic [31:0] h0,
                         input logic [31:0] l1, input logic [31:0] h1);
        cfg_phase = 2'(ph); cfg_inv = 2'(iv);
        roi_x0 = 16'(x0); roi_y0 = 16'(y0); roi_x1 = 16'(x1); roi_y1 = 16'(y1);
        zone_w = 16'(zw); zone_h = 16'(zh);
        lim_lo0 = l0; lim_hi0 = h0; lim_lo1 = l1; lim_hi1 = h1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            vecs++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(frame_sum == 8'd0, "R1", "frame_sum after reset", frame_sum, 0);
        for (int i = 0; i < 49; i++) begin es0[i] = 0; es1[i] = 0; ec[i] = 0; end
        check_zones("R1");
        cmp_on = 1'b1;

        // R4 R7 R8: full frame, wide bounds, 2x2 zones, columns past the grid dropped
        setup(0, 0, 0, 0, 16, 12, 2, 2, 32'h0, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF);
        fill(0, 16, 12);
        model();
        send_frame(16, 12, 1'b0, 1'b0);
        check_zones("R4 R7 R8");

        // R9: next frame clears, and everything is rejected (lo above hi)
        setup(0, 0, 0, 0, 16, 12, 2, 2, 32'h00100000, 32'h00010000, 32'h0, 32'hFFFFFFFF);
        fill(3, 16, 12);
        model();
        send_frame(16, 12, 1'b0, 1'b1);
        check_zones("R9 R5");

        // R3 R5 R6: phase 01, invert 10, inner region, 4x2 zones, tight bounds
        setup(1, 2, 2, 2, 18, 12, 4, 2, 32'h00008000, 32'h00020000, 32'h00004000, 32'h00030000);
        fill(1, 20, 14);
        model();
        send_frame(20, 14, 1'b1, 1'b0);
        check_zones("R3 R5 R6");

        // R4 R5 R7: zero denominators saturate; X0 accepts saturation, X1 limit just below it
        setup(3, 1, 0, 4, 32, 20, 2, 2, 32'h0, 32'h00FFFFFF, 32'h0, 32'h00FF0000);
        fill(2, 32, 20);
        model();
        send_frame(32, 20, 1'b1, 1'b0);
        check_zones("R4 R5 R7");

        // R3 R7: phase 10, invert 11, 6x4 zones
        setup(2, 3, 0, 0, 16, 16, 6, 4, 32'h0, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF);
        fill(0, 16, 16);
        model();
        send_frame(16, 16, 1'b0, 1'b0);
        check_zones("R3 R7");

        // R10: indices past the last zone read zero
        for (int z = 49; z < 64; z += 7) begin
            @(negedge clk);
            rd_zone = 6'(z);
            #1;
            check(rd_sum0 == '0 && rd_sum1 == '0 && rd_count == '0, "R10",
                  $sformatf("zone %0d out of range", z), longint'(rd_sum0), 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule